// File: doc/BRIEF.md
# Intel-style register bus slave

This block lets an external microprocessor read and write a small on-chip register file over an asynchronous parallel bus. The bus has these signals:

- a 7-bit address, captured with an address-latch-enable strobe;
- an active-low chip select;
- separate active-low read and write strobes;
- an 8-bit bidirectional data bus;
- a ready output that tells the host when read data may be sampled.

All bus inputs pass through two-flop synchronizers into the system clock domain. The block detects strobe edges there and keeps a 128 x 8 register array that is written so that a block RAM can be inferred.

In the address phase the host raises the latch enable, places the address and pulls chip select low. It then drops the latch enable, and that falling edge fixes the target register. For a read, the host pulls the read strobe low. The block then drives the data bus with the addressed register, pulls ready low, and raises ready a fixed number of system clocks later. The read ends when the host returns the strobe high. For a write, the host places data and pulses the write strobe low. The register is updated when the strobe rises.

After reset a sweep engine writes zero into every entry, one entry per clock. This makes the whole register file start at zero without a reset port on the memory.

Top module: `hostbus_regslave`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `bus_rdy` is 1 and the data bus is not driven.
- R2: Within 2^ADDR_W clocks after reset is released, every register reads back 0x00.
- R3: While `bus_ale` is high the latched address follows `bus_addr`. After `bus_ale` falls, the value it had just before the fall selects the register, and later changes of `bus_addr` are ignored.
- R4: With `bus_cs_n` low, a low-to-high transition of `bus_wr_n` stores the value on `bus_data` into the register at the latched address.
- R5: With `bus_cs_n` high, read and write strobes are ignored: no register changes, `bus_rdy` stays 1 and the data bus is not driven.
- R6: A read with `bus_cs_n` low drives the contents of the latched register onto `bus_data`, and the value is valid once `bus_rdy` is 1.
- R7: `bus_rdy` goes low on the third rising clock edge after `bus_rd_n` falls (two synchronizer stages plus edge detection). It stays low for exactly RDY_DLY clocks.
- R8: When the synchronized `bus_rd_n` (or `bus_cs_n`) is seen high, the block releases the data bus and sets `bus_rdy` to 1 on the next clock edge. This is the third edge after the pin changes.
- R9: If `bus_rd_n` returns high before `bus_rdy` has risen, the read ends early. `bus_rdy` rises on the third edge after the strobe rose, without completing the wait.
- R10: `bus_rdy` is 1 for the whole of a write cycle and whenever no read is in progress.
- R11: A write whose strobe rise is detected while the post-reset clear sweep runs is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address from the host |
| bus_ale | input | 1 | Address latch enable, transparent while high |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_wr_n | input | 1 | Write strobe, active low, commits on rising edge |
| bus_data | inout | DATA_W | Bidirectional data bus |
| bus_rdy | output | 1 | Ready, low while read data is not yet valid |

## Verification
The assertions check on every cycle the relations between ready and the output enable:

- ready is high whenever no read is driving;
- ready drops at the start of every read and stays low for exactly the configured wait when the read completes normally;
- the bus is released one clock after the synchronized read strobe returns high;
- a read starts only after chip select was seen low.

Register contents can only be shown by the bench's scenarios, which read values back over the bus. These scenarios cover:

- the address chosen at the falling latch-enable edge;
- cycles with chip select high;
- the early end of a read;
- a write dropped during the clear sweep;
- release of the data bus.

// File: rtl/hb_pkg.sv
package hb_pkg;

  // read-side state of the bus controller
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_RD_WAIT  = 2'd1,
    ST_RD_VALID = 2'd2
  } rd_state_t;

  // width of a down counter that must hold the value n
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/hb_sync.sv
// Multi-stage synchronizer for a vector of asynchronous pins.
module hb_sync #(
  parameter int            W       = 1,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/hb_addr_hold.sv
// Address holding register: follows the synchronized address while the
// synchronized latch enable is high, keeps the last value once it drops.
module hb_addr_hold #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ale_s,
  input  logic [AW-1:0] addr_s,
  output logic [AW-1:0] addr_q
);

  always_ff @(posedge clk) begin
    if (rst)        addr_q <= '0;
    else if (ale_s) addr_q <= addr_s;
  end

endmodule

// File: rtl/hb_regfile.sv
// Register array with a post-reset zero sweep. The array itself has no
// reset so that it maps onto block RAM; the sweep owns the write port
// for 2**AW cycles after reset.
module hb_regfile #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_waddr,
  input  logic [DW-1:0] bus_wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  output logic          clr_busy
);

  localparam int            DEPTH = 1 << AW;
  localparam logic [AW-1:0] LAST  = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] clr_addr;
  logic          we;
  logic [AW-1:0] wa;
  logic [DW-1:0] wd;

  always_ff @(posedge clk) begin
    if (rst) begin
      clr_busy <= 1'b1;
      clr_addr <= '0;
    end else if (clr_busy) begin
      clr_addr <= clr_addr + 1'b1;
      if (clr_addr == LAST) clr_busy <= 1'b0;
    end
  end

  // sweep has priority; bus writes during the sweep are dropped
  always_comb begin
    we = clr_busy | bus_we;
    wa = clr_busy ? clr_addr : bus_waddr;
    wd = clr_busy ? '0 : bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= mem[raddr];
  end

endmodule

// File: rtl/hb_bus_ctrl.sv
// Strobe edge detection and read/write sequencing in the clock domain.
module hb_bus_ctrl
  import hb_pkg::*;
#(
  parameter int RDY_DLY = 2   // clocks of ready low per read, >= 1
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n_s,
  input  logic rd_n_s,
  input  logic wr_n_s,
  input  logic hold_wr,
  output logic oe_q,
  output logic rdy_q,
  output logic wr_fire
);

  localparam int CW = cnt_width(RDY_DLY);
  localparam logic [CW-1:0] CNT_LOAD = CW'(RDY_DLY);

  rd_state_t     state;
  logic          rd_d, wr_d;
  logic          rd_fall, wr_rise;
  logic [CW-1:0] cnt;
  logic          rd_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_d <= 1'b1;
      wr_d <= 1'b1;
    end else begin
      rd_d <= rd_n_s;
      wr_d <= wr_n_s;
    end
  end

  assign rd_fall = rd_d & ~rd_n_s;
  assign wr_rise = ~wr_d & wr_n_s;
  assign rd_end  = rd_n_s | cs_n_s;

  assign wr_fire = (state == ST_IDLE) & ~cs_n_s & wr_rise & ~hold_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      oe_q  <= 1'b0;
      rdy_q <= 1'b1;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (rd_fall && !cs_n_s) begin
            state <= ST_RD_WAIT;
            oe_q  <= 1'b1;
            rdy_q <= 1'b0;
            cnt   <= CNT_LOAD;
          end
        end
        ST_RD_WAIT: begin
          if (rd_end) begin
            state <= ST_IDLE;
            oe_q  <= 1'b0;
            rdy_q <= 1'b1;
          end else if (cnt == CW'(1)) begin
            state <= ST_RD_VALID;
            rdy_q <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_RD_VALID: begin
          if (rd_end) begin
            state <= ST_IDLE;
            oe_q  <= 1'b0;
          end
        end
        default: begin
          state <= ST_IDLE;
          oe_q  <= 1'b0;
          rdy_q <= 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/hostbus_regslave.sv
// Register file slave on an asynchronous parallel host bus.
module hostbus_regslave #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int RDY_DLY     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_ale,
  input  logic              bus_cs_n,
  input  logic              bus_rd_n,
  input  logic              bus_wr_n,
  inout  wire  [DATA_W-1:0] bus_data,
  output logic              bus_rdy
);

  localparam int CTL_W = 4;

  logic [CTL_W-1:0]  s_ctl;
  logic              s_ale, s_cs_n, s_rd_n, s_wr_n;
  logic [ADDR_W-1:0] s_addr;
  logic [DATA_W-1:0] s_data;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] rd_data;
  logic              clr_busy;
  logic              oe_q, rdy_q, wr_fire;

  // strobes reset to their inactive levels
  hb_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(4'b0111)) u_sync_ctl (
    .clk (clk), .rst (rst),
    .d   ({bus_ale, bus_cs_n, bus_rd_n, bus_wr_n}),
    .q   (s_ctl)
  );

  hb_sync #(.W(ADDR_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_addr (
    .clk (clk), .rst (rst), .d (bus_addr), .q (s_addr)
  );

  hb_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_data (
    .clk (clk), .rst (rst), .d (bus_data), .q (s_data)
  );

  assign {s_ale, s_cs_n, s_rd_n, s_wr_n} = s_ctl;

  hb_addr_hold #(.AW(ADDR_W)) u_addr (
    .clk    (clk),
    .rst    (rst),
    .ale_s  (s_ale),
    .addr_s (s_addr),
    .addr_q (lat_addr)
  );

  hb_bus_ctrl #(.RDY_DLY(RDY_DLY)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .cs_n_s  (s_cs_n),
    .rd_n_s  (s_rd_n),
    .wr_n_s  (s_wr_n),
    .hold_wr (clr_busy),
    .oe_q    (oe_q),
    .rdy_q   (rdy_q),
    .wr_fire (wr_fire)
  );

  hb_regfile #(.AW(ADDR_W), .DW(DATA_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (wr_fire),
    .bus_waddr (lat_addr),
    .bus_wdata (s_data),
    .raddr     (lat_addr),
    .rdata     (rd_data),
    .clr_busy  (clr_busy)
  );

  assign bus_data = oe_q ? rd_data : {DATA_W{1'bz}};
  assign bus_rdy  = rdy_q;

endmodule

// File: rtl/hostbus_regslave_chk.sv
// Protocol checker attached to the bus slave.
module hostbus_regslave_chk #(
  parameter int RDY_DLY = 2
) (
  input logic clk,
  input logic rst,
  input logic bus_rdy,
  input logic oe_q,
  input logic s_cs_n,
  input logic s_rd_n
);

  logic [15:0] low_run;

  always_ff @(posedge clk) begin
    if (rst)               low_run <= '0;
    else if (!bus_rdy) begin
      if (low_run != 16'hFFFF) low_run <= low_run + 16'd1;
    end else               low_run <= '0;
  end

  // R1: reset leaves ready high and the bus released
  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (bus_rdy && !oe_q));

  // R10: ready high whenever no read drives the bus
  p_idle_ready_r10: assert property (@(posedge clk) disable iff (rst)
    !oe_q |-> bus_rdy);

  // R7: ready drops as the drivers turn on
  p_read_start_low_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(oe_q) |-> !bus_rdy);

  // R7: a completed wait lasts exactly RDY_DLY clocks
  p_ready_window_r7: assert property (@(posedge clk) disable iff (rst)
    ($rose(bus_rdy) && oe_q) |-> (low_run == 16'(RDY_DLY)));

  // R8: drivers released one clock after the synchronized strobe rises
  p_release_after_end_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(s_rd_n) |=> !oe_q);

  // R5: a read only starts after chip select was seen low
  p_start_needs_cs_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(oe_q) |-> !$past(s_cs_n));

endmodule

bind hostbus_regslave hostbus_regslave_chk #(.RDY_DLY(RDY_DLY)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .bus_rdy (bus_rdy),
  .oe_q    (oe_q),
  .s_cs_n  (s_cs_n),
  .s_rd_n  (s_rd_n)
);

// File: tb/test_hostbus_regslave.sv
`timescale 1ns/1ps
module test_hostbus_regslave;

  localparam int DLY = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] bus_addr = '0;
  logic       bus_ale = 1'b0;
  logic       bus_cs_n = 1'b1;
  logic       bus_rd_n = 1'b1;
  logic       bus_wr_n = 1'b1;
  wire  [7:0] bus_data;
  logic       bus_rdy;
  logic [7:0] tb_val = '0;
  logic       tb_en = 1'b0;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  assign bus_data = tb_en ? tb_val : 8'bz;

  hostbus_regslave #(.RDY_DLY(DLY)) i_hostbus_regslave (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_ale  (bus_ale),
    .bus_cs_n (bus_cs_n),
    .bus_rd_n (bus_rd_n),
    .bus_wr_n (bus_wr_n),
    .bus_data (bus_data),
    .bus_rdy  (bus_rdy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic addr_phase(input logic [6:0] a, input bit use_cs);
    bus_ale  = 1'b1;
    bus_addr = a;
    @(negedge clk);
    bus_cs_n = ~use_cs;
    repeat (2) @(negedge clk);
    bus_ale = 1'b0;
    @(negedge clk);
    bus_addr = ~a;            // ignored after the latch edge (R3)
    repeat (3) @(negedge clk);
  endtask

  task automatic end_cycle();
    bus_cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] d, input bit use_cs);
    addr_phase(a, use_cs);
    tb_val = d;
    tb_en  = 1'b1;
    @(negedge clk);
    bus_wr_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(bus_rdy == 1'b1, "R10 ready during write", bus_rdy, 1);
    end
    bus_wr_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(bus_rdy == 1'b1, "R10 ready after write", bus_rdy, 1);
    end
    tb_en = 1'b0;
    end_cycle();
  endtask

  // bus released: a bench drive of 0 must be seen unchanged
  task automatic release_check(input string req);
    tb_val = 8'h00;
    tb_en  = 1'b1;
    #2;
    check(bus_data == 8'h00, req, bus_data, 0);
    tb_en = 1'b0;
  endtask

  task automatic do_read(input logic [6:0] a, input logic [7:0] exp, input string req);
    logic exp_rdy;
    addr_phase(a, 1'b1);
    bus_rd_n = 1'b0;
    for (int i = 1; i <= DLY + 3; i++) begin
      @(negedge clk);
      exp_rdy = (i >= 3 && i <= DLY + 2) ? 1'b0 : 1'b1;
      check(bus_rdy == exp_rdy, "R7 ready timing", bus_rdy, exp_rdy);
    end
    check(bus_data == exp, req, bus_data, exp);
    bus_rd_n = 1'b1;
    repeat (2) @(negedge clk);
    check(bus_rdy == 1'b1, "R8 ready high after end", bus_rdy, 1);
    @(negedge clk);
    release_check("R8 bus released after read");
    end_cycle();
  endtask

  task automatic t_reset_and_clear();
    rst = 1'b1;
    repeat (5) @(negedge clk);
    check(bus_rdy == 1'b1, "R1 ready in reset", bus_rdy, 1);
    release_check("R1 bus released in reset");
    rst = 1'b0;
    @(negedge clk);
    check(bus_rdy == 1'b1, "R1 ready after reset", bus_rdy, 1);
    // write issued while the sweep is still running must be dropped
    do_write(7'h05, 8'h5A, 1'b1);
    repeat (140) @(negedge clk);
    do_read(7'h00, 8'h00, "R2 cleared entry 0");
    do_read(7'h7F, 8'h00, "R2 cleared entry 127");
    do_read(7'h05, 8'h00, "R11 write during clear dropped");
  endtask

  task automatic t_write_patterns();
    do_write(7'h00, 8'hA5, 1'b1);
    do_write(7'h7F, 8'h5A, 1'b1);
    do_write(7'h40, 8'hFF, 1'b1);
    do_write(7'h01, 8'h01, 1'b1);
    do_read(7'h00, 8'hA5, "R4 R6 data at 0x00");
    do_read(7'h7F, 8'h5A, "R4 R6 data at 0x7F");
    do_read(7'h40, 8'hFF, "R4 R6 data at 0x40");
    do_read(7'h01, 8'h01, "R4 R6 data at 0x01");
  endtask

  task automatic t_addr_latch();
    // 0x6E is the complement of 0x11, driven after the latch edge
    do_write(7'h6E, 8'hC3, 1'b1);
    do_write(7'h11, 8'h3C, 1'b1);
    do_read(7'h11, 8'h3C, "R3 falling edge address kept");
    do_read(7'h6E, 8'hC3, "R3 later address ignored");
  endtask

  task automatic t_cs_high();
    do_write(7'h40, 8'h12, 1'b0);
    do_read(7'h40, 8'hFF, "R5 write with CS high ignored");
    addr_phase(7'h40, 1'b0);
    bus_rd_n = 1'b0;
    for (int i = 0; i < DLY + 4; i++) begin
      @(negedge clk);
      check(bus_rdy == 1'b1, "R5 ready with CS high", bus_rdy, 1);
    end
    release_check("R5 bus not driven with CS high");
    bus_rd_n = 1'b1;
    end_cycle();
  endtask

  task automatic t_early_end();
    addr_phase(7'h7F, 1'b1);
    bus_rd_n = 1'b0;
    repeat (3) @(negedge clk);
    check(bus_rdy == 1'b0, "R9 ready low at start", bus_rdy, 0);
    bus_rd_n = 1'b1;
    repeat (2) @(negedge clk);
    check(bus_rdy == 1'b0, "R9 ready low before end seen", bus_rdy, 0);
    @(negedge clk);
    check(bus_rdy == 1'b1, "R9 ready high on early end", bus_rdy, 1);
    @(negedge clk);
    release_check("R9 bus released on early end");
    end_cycle();
  endtask

  initial begin
    t_reset_and_clear();
    t_write_patterns();
    t_addr_latch();
    t_cs_high();
    t_early_end();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule